// File: doc/BRIEF.md
# Programmable Bidirectional Pin Cell

This cell sits between a bundle of routing channels and one device pin. A channel multiplexer picks one of `NCH` channel lines as the outgoing data. The cell holds one storage register, and configuration places it either in the outgoing path or in the incoming path, or leaves it out of both. A tristate output stage drives the pin when its enable is active. The cell always returns the pin value to two channel lines.

The register's capture strobe, its clear and the output enable all come from a shared control bus. That bus has two strobe lines and two clear lines. Each control has its own line select and its own inversion bit. The second strobe line and the second clear line can also serve as the output enable.

The pin is presented as three separate signals: driven value, drive enable and external value. A pin model outside the cell resolves them. While the cell drives, the incoming path sees the cell's own driven value. While it does not drive, the pin is high impedance and the incoming path reads the external value.

Top module: `pio_cell`

## Requirements
- R1: The selected channel is `chan_in[cfg_sel]` when `cfg_sel` < NCH. A select value of NCH or above yields 0. Outside output-register mode, `pad_o` follows the selected channel in the same cycle.
- R2: `pad_oe` equals the raw enable XOR `cfg_oe_inv`. The raw enable follows the `cfg_oe_src` code: 0 gives constant 0, 1 gives constant 1, 2 gives `pclk[1]`, 3 gives `pclr[1]`.
- R3: The pin value is `pad_o` while `pad_oe` is 1 and `pad_i` while `pad_oe` is 0. Outside input-register mode, the incoming path shows the pin value in the same cycle.
- R4: In output-register mode (`cfg_reg_mode` = 2), `pad_o` shows the register. At a rising `clk` edge with the strobe active, the register loads the selected channel. With the strobe inactive, it holds.
- R5: In input-register mode (`cfg_reg_mode` = 1), `chan_out` shows the register. At a rising `clk` edge with the strobe active, the register loads the pin value.
- R6: The strobe is `pclk[cfg_clk_sel]` XOR `cfg_clk_inv`. It acts as a clock enable sampled at rising edges of `clk`.
- R7: The clear is active when `cfg_clr_en` is 1 and `pclr[cfg_clr_sel]` XOR `cfg_clr_inv` is 1. While it is active, the register is 0 at once, without waiting for a clock edge. This overrides the strobe.
- R8: `chan_out[0]` and `chan_out[1]` always carry the same incoming value.
- R9: While `rst_n` is low, the register is 0.
- R10: With `cfg_reg_mode` 0 or 3, both paths are combinational and the register is not visible at any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | SEL_W | Outgoing channel select |
| cfg_reg_mode | input | 2 | Register placement: 0 none, 1 incoming, 2 outgoing, 3 none |
| cfg_clk_sel | input | 1 | Strobe line select |
| cfg_clk_inv | input | 1 | Strobe inversion |
| cfg_clr_en | input | 1 | Clear use enable |
| cfg_clr_sel | input | 1 | Clear line select |
| cfg_clr_inv | input | 1 | Clear inversion |
| cfg_oe_src | input | 2 | Output enable source code |
| cfg_oe_inv | input | 1 | Output enable inversion |
| pclk | input | 2 | Shared strobe lines |
| pclr | input | 2 | Shared clear lines |
| chan_in | input | NCH | Routing channel lines |
| chan_out | output | 2 | Incoming value to two channel lines |
| pad_o | output | 1 | Value driven toward the pin |
| pad_oe | output | 1 | Pin drive enable (0 means high impedance) |
| pad_i | input | 1 | External value at the pin |

## Verification
The hardest situation to reach is the asynchronous clear when it lands between clock edges. It also has to race a strobe that is active in the same cycle, and the register has to be in a path the ports can see. The stimulus randomises the strobe and clear lines on every cycle while the register is in the outgoing and the incoming positions. It also takes the output enable from the second clear line, so clear, drive and capture change together.

Loopback capture is reached by input-register mode with the drive enabled. Select values past the last channel are driven directly.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PBUS   = 2;
  localparam int PSEL_W = (PBUS > 1) ? $clog2(PBUS) : 1;
  localparam int NLINE  = 2;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_IN   = 2'd1,
    REG_OUT  = 2'd2,
    REG_NONE2 = 2'd3
  } reg_mode_e;

  typedef enum logic [1:0] {
    OE_OFF  = 2'd0,
    OE_ON   = 2'd1,
    OE_CLK1 = 2'd2,
    OE_CLR1 = 2'd3
  } oe_src_e;
endpackage

// File: rtl/pio_ctl.sv
module pio_ctl
  import pio_pkg::*;
(
  input  logic [PBUS-1:0]   pclk,
  input  logic [PBUS-1:0]   pclr,
  input  logic [PSEL_W-1:0] cfg_clk_sel,
  input  logic              cfg_clk_inv,
  input  logic              cfg_clr_en,
  input  logic [PSEL_W-1:0] cfg_clr_sel,
  input  logic              cfg_clr_inv,
  input  oe_src_e           oe_src,
  input  logic              cfg_oe_inv,
  output logic              stb,
  output logic              clr_act,
  output logic              oe
);
  logic oe_raw;

  always_comb begin
    stb     = pclk[cfg_clk_sel] ^ cfg_clk_inv;
    clr_act = cfg_clr_en & (pclr[cfg_clr_sel] ^ cfg_clr_inv);
    case (oe_src)
      OE_OFF:  oe_raw = 1'b0;
      OE_ON:   oe_raw = 1'b1;
      OE_CLK1: oe_raw = pclk[PBUS-1];
      default: oe_raw = pclr[PBUS-1];
    endcase
    oe = oe_raw ^ cfg_oe_inv;
  end
endmodule

// File: rtl/pio_chmux.sv
module pio_chmux #(
  parameter int NCH   = 21,
  parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]   ch,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  always_comb begin
    dout = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == SEL_W'(i)) dout = ch[i];
    end
  end
endmodule

// File: rtl/pio_reg.sv
module pio_reg (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= 1'b0;
    else         q <= q_nxt;
  end
endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
#(
  parameter int NCH   = 21,
  parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_reg_mode,
  input  logic [PSEL_W-1:0] cfg_clk_sel,
  input  logic              cfg_clk_inv,
  input  logic              cfg_clr_en,
  input  logic [PSEL_W-1:0] cfg_clr_sel,
  input  logic              cfg_clr_inv,
  input  logic [1:0]        cfg_oe_src,
  input  logic              cfg_oe_inv,
  input  logic [PBUS-1:0]   pclk,
  input  logic [PBUS-1:0]   pclr,
  input  logic [NCH-1:0]    chan_in,
  output logic [NLINE-1:0]  chan_out,
  output logic              pad_o,
  output logic              pad_oe,
  input  logic              pad_i
);
  reg_mode_e mode;
  logic      stb, clr_act, oe;
  logic      sel_data, q, reg_d, pin_val, in_val, reg_rst_n;

  assign mode = reg_mode_e'(cfg_reg_mode);

  pio_ctl u_ctl (
    .pclk        (pclk),
    .pclr        (pclr),
    .cfg_clk_sel (cfg_clk_sel),
    .cfg_clk_inv (cfg_clk_inv),
    .cfg_clr_en  (cfg_clr_en),
    .cfg_clr_sel (cfg_clr_sel),
    .cfg_clr_inv (cfg_clr_inv),
    .oe_src      (oe_src_e'(cfg_oe_src)),
    .cfg_oe_inv  (cfg_oe_inv),
    .stb         (stb),
    .clr_act     (clr_act),
    .oe          (oe)
  );

  pio_chmux #(.NCH(NCH), .SEL_W(SEL_W)) u_mux (
    .ch   (chan_in),
    .sel  (cfg_sel),
    .dout (sel_data)
  );

  // Clear is folded into the register's asynchronous reset.
  assign reg_rst_n = rst_n & ~clr_act;

  pio_reg u_reg (
    .clk    (clk),
    .arst_n (reg_rst_n),
    .en     (stb),
    .d      (reg_d),
    .q      (q)
  );

  always_comb begin
    pad_o   = (mode == REG_OUT) ? q : sel_data;
    pad_oe  = oe;
    pin_val = oe ? pad_o : pad_i;
    reg_d   = (mode == REG_OUT) ? sel_data : pin_val;
    in_val  = (mode == REG_IN) ? q : pin_val;
  end

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    assign chan_out[g] = in_val;
  end
endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk
  import pio_pkg::*;
#(
  parameter int NCH   = 21,
  parameter int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [1:0]        cfg_reg_mode,
  input logic [PSEL_W-1:0] cfg_clk_sel,
  input logic              cfg_clk_inv,
  input logic              cfg_clr_en,
  input logic [PSEL_W-1:0] cfg_clr_sel,
  input logic              cfg_clr_inv,
  input logic [1:0]        cfg_oe_src,
  input logic              cfg_oe_inv,
  input logic [PBUS-1:0]   pclk,
  input logic [PBUS-1:0]   pclr,
  input logic [NCH-1:0]    chan_in,
  input logic [NLINE-1:0]  chan_out,
  input logic              pad_o,
  input logic              pad_oe,
  input logic              pad_i
);
  logic c_stb, c_clr, c_out, c_in;
  assign c_stb = pclk[cfg_clk_sel] ^ cfg_clk_inv;
  assign c_clr = cfg_clr_en & (pclr[cfg_clr_sel] ^ cfg_clr_inv);
  assign c_out = (cfg_reg_mode == 2'd2);
  assign c_in  = (cfg_reg_mode == 2'd1);

  p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe_src == 2'd0 && !cfg_oe_inv) |-> !pad_oe);

  p_lines_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_out[0] == chan_out[NLINE-1]);

  p_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_oe && (cfg_reg_mode == 2'd0 || cfg_reg_mode == 2'd3)) |-> chan_out[0] == pad_i);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr && c_out) |-> !pad_o);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out && c_stb && !c_clr && cfg_sel < SEL_W'(NCH)) |=>
      (c_clr || !c_out || pad_o == $past(chan_in[cfg_sel])));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_out && $past(c_out) && !$past(c_stb) && !$past(c_clr) && !c_clr) |-> $stable(pad_o));

  p_in_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in && c_stb && !c_clr && !pad_oe) |=>
      (c_clr || !c_in || chan_out[0] == $past(pad_i)));
endmodule

bind pio_cell pio_cell_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/pio_cell_test.sv
module pio_cell_test;
  localparam int NCH = 21;
  localparam int SW  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [SW-1:0] cfg_sel;
  logic [1:0] cfg_reg_mode, cfg_oe_src;
  logic cfg_clk_sel, cfg_clk_inv, cfg_clr_en, cfg_clr_sel, cfg_clr_inv, cfg_oe_inv;
  logic [1:0] pclk, pclr;
  logic [NCH-1:0] chan_in;
  logic [1:0] chan_out;
  logic pad_o, pad_oe, pad_i;

  int tests = 0;
  int fails = 0;
  bit clr_rand;
  bit done = 0;
  logic mq;

  always #5 clk = ~clk;

  pio_cell #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_reg_mode(cfg_reg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv), .cfg_clr_en(cfg_clr_en),
    .cfg_clr_sel(cfg_clr_sel), .cfg_clr_inv(cfg_clr_inv), .cfg_oe_src(cfg_oe_src),
    .cfg_oe_inv(cfg_oe_inv), .pclk(pclk), .pclr(pclr), .chan_in(chan_in),
    .chan_out(chan_out), .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i)
  );

  // Behavioural reference
  function automatic logic f_sel();
    return (int'(cfg_sel) < NCH) ? chan_in[cfg_sel] : 1'b0;
  endfunction
  function automatic logic f_oe();
    logic r;
    case (cfg_oe_src)
      2'd0: r = 1'b0;
      2'd1: r = 1'b1;
      2'd2: r = pclk[1];
      default: r = pclr[1];
    endcase
    return r ^ cfg_oe_inv;
  endfunction
  function automatic logic f_clr();
    return cfg_clr_en && (pclr[cfg_clr_sel] ^ cfg_clr_inv);
  endfunction
  function automatic logic f_pado(logic q);
    return (cfg_reg_mode == 2'd2) ? q : f_sel();
  endfunction
  function automatic logic f_pin(logic q);
    return f_oe() ? f_pado(q) : pad_i;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || f_clr()) mq = 1'b0;
    else if (pclk[cfg_clk_sel] ^ cfg_clk_inv)
      mq = (cfg_reg_mode == 2'd2) ? f_sel() : f_pin(mq);
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n !== 1'bx && !done) begin
      logic ein;
      string tg;
      if (!rst_n || f_clr()) mq = 1'b0;
      ein = (cfg_reg_mode == 2'd1) ? mq : f_pin(mq);
      chk("R2", "pad_oe", pad_oe, f_oe());
      if (!rst_n) tg = "R9";
      else if (f_clr()) tg = "R7";
      else if (cfg_reg_mode == 2'd2) tg = cfg_clk_inv ? "R6" : "R4";
      else tg = "R1";
      chk(tg, "pad_o", pad_o, f_pado(mq));
      if (!rst_n) tg = "R9";
      else if (cfg_reg_mode == 2'd1) tg = f_clr() ? "R7" : "R5";
      else if (cfg_reg_mode == 2'd0 || cfg_reg_mode == 2'd3) tg = "R10";
      else tg = "R3";
      chk(tg, "chan_out0", chan_out[0], ein);
      chk("R8", "chan_out1", chan_out[1], ein);
    end
  end

  task automatic cfg(logic [1:0] mode, logic [1:0] oes, logic oei,
                     logic cs, logic ci, logic ce, logic rs, logic ri);
    cfg_reg_mode = mode; cfg_oe_src = oes; cfg_oe_inv = oei;
    cfg_clk_sel = cs; cfg_clk_inv = ci; cfg_clr_en = ce;
    cfg_clr_sel = rs; cfg_clr_inv = ri;
  endtask

  task automatic run(int n, bit vary_sel);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      chan_in = NCH'($urandom);
      pclk = 2'($urandom);
      pclr = clr_rand ? 2'($urandom) : 2'b00;
      pad_i = 1'($urandom);
      if (vary_sel) cfg_sel = SW'($urandom_range(0, 31));
    end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_sel = '0; chan_in = '1; pclk = 2'b11; pclr = 2'b00; pad_i = 1'b1;
    clr_rand = 0;
    cfg(2'd2, 2'd1, 0, 0, 0, 0, 0, 0);   // R9: register held at 0 in reset
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 / R10: combinational paths, drive on, select sweeps incl. 20 and >= 21
    cfg(2'd0, 2'd1, 0, 0, 0, 0, 0, 0);
    run(40, 1);
    cfg_sel = 5'd20; run(4, 0);
    cfg_sel = 5'd25; run(4, 0);
    // R3: high impedance, input reads pad_i; mode code 3
    cfg(2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
    run(20, 1);
    // R2: inverted off source means on
    cfg(2'd0, 2'd0, 1, 0, 0, 0, 0, 0);
    run(10, 1);
    // R4: output register, strobe line 0
    cfg(2'd2, 2'd1, 0, 0, 0, 0, 0, 0);
    cfg_sel = 5'd7; run(30, 0);
    // R6: strobe line 1 inverted
    cfg(2'd2, 2'd1, 0, 1, 1, 0, 0, 0);
    run(30, 1);
    // R5: input register, pin undriven
    cfg(2'd1, 2'd0, 0, 0, 0, 0, 0, 0);
    run(30, 1);
    // R5 / R3: input register capturing own driven value
    cfg(2'd1, 2'd1, 0, 1, 0, 0, 0, 0);
    run(30, 1);
    // R7: random clear, output enable from clear line 1
    clr_rand = 1;
    cfg(2'd2, 2'd3, 0, 0, 0, 1, 0, 0);
    run(40, 1);
    cfg(2'd1, 2'd3, 1, 0, 0, 1, 1, 1);
    run(40, 1);
    // R2: enable from strobe line 1, inverted
    cfg(2'd0, 2'd2, 1, 0, 0, 0, 0, 0);
    run(20, 1);
    @(posedge clk); #2;
    @(negedge clk); #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule